// File: doc/BRIEF.md
# Priority Interrupt Arbiter with Suppression

This block collects every interrupt source of a small stack processor and decides which one the core takes next. The sources are a non-maskable interrupt, stack error lines, plain level-sensitive lines, timer lines that count only their rising edge, and a software interrupt flag that the core sets and clears through I/O writes. A configuration bit picks how the non-maskable interrupt behaves. With the bit set, the core's critical-sequence suppress signal can hold it off. With the bit clear, nothing holds it off.

Two suppress inputs hold back requests while critical work is in progress. The external suppress line holds back every source except the non-maskable interrupt. The core's internal suppress line holds back the same sources and also the suppressible mode of the non-maskable interrupt. While anything is eligible, the arbiter raises a request to the core. The core answers with an acknowledge strobe that it holds for two cycles. The arbiter latches a 4-bit vector code on the first acknowledge cycle and consumes the chosen source on the second. Code 0 means "no interrupt". It is returned when the acknowledge finds nothing eligible, when the chosen source has gone away, or when the acknowledge is too short.

Top module: `irq_prio_arb`

## Requirements
- R1: Source codes are fixed. The non-maskable interrupt is code 1, stack error lines are codes 2..3, level lines are codes 4..7, timer lines are codes 8..10 and the software flag is code 11. Among the eligible sources the lowest code wins. `irq_o` is high in the same cycle whenever any source is eligible.
- R2: While `ext_sup_i` is high, no source other than the non-maskable interrupt is eligible. The non-maskable interrupt stays eligible in both modes.
- R3: While `core_sup_i` is high, no maskable source is eligible. The non-maskable interrupt is also held off when `nmi_mode_i` is 1, and is never held off when `nmi_mode_i` is 0.
- R4: When suppression ends, requests raised during it are served in code order, but only those still asserted at that moment.
- R5: On the first cycle of an acknowledge (the first cycle with `ack_i` high), the winning code is latched. `vec_o` shows it from the following cycle.
- R6: If nothing is eligible on the first acknowledge cycle, `vec_o` becomes code 0.
- R7: If the chosen source is no longer requesting on the second acknowledge cycle, `vec_o` becomes code 0 and nothing is consumed.
- R8: If `ack_i` lasts only one cycle, `vec_o` becomes code 0 in the next cycle and the chosen source stays pending.
- R9: A rising edge on a timer line sets that timer's pending request. The request is cleared by the second cycle of an acknowledge that chose it, or by a one-cycle pulse on its `tmr_rd_i` bit. When a new edge and a clear land in the same cycle, the edge wins.
- R10: A cycle with `swi_we_i` high loads `swi_wd_i` into the software flag, and `swi_q_o` shows it in the next cycle. An acknowledge never clears the flag.
- R11: After reset, `irq_o`, `vec_o`, `swi_q_o` and all timer pending requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| nmi_i | input | 1 | Non-maskable interrupt request, level |
| nmi_mode_i | input | 1 | 1: the internal suppress can hold off the non-maskable interrupt; 0: never held off |
| stk_err_i | input | 2 | Stack error requests, level |
| lvl_req_i | input | 4 | General level-sensitive requests |
| tmr_i | input | 3 | Timer request lines, rising-edge sensitive |
| tmr_rd_i | input | 3 | Per-timer clear pulse from a software read of the timer |
| swi_we_i | input | 1 | Write strobe for the software interrupt flag |
| swi_wd_i | input | 1 | Value written to the software interrupt flag |
| ext_sup_i | input | 1 | External suppress; holds back maskable sources |
| core_sup_i | input | 1 | Core critical-sequence suppress |
| ack_i | input | 1 | Acknowledge strobe from the core |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | 4 | Vector code; 0 means no interrupt |
| swi_q_o | output | 1 | Read-back of the software interrupt flag |

## Verification
The in-line properties check every cycle that the suppressible non-maskable interrupt never raises `irq_o` under core suppression, and that external suppression never hides it. They also check that a one-cycle or empty acknowledge yields code 0, that timer edges always latch, that at most one timer is consumed per acknowledge, and that software flag writes load the written value. The following can only be shown by the bench's scenarios: the full ordering among many simultaneous requests, that a withdrawn request is skipped after suppression ends, that a consumed timer stops requesting, and that a one-cycle acknowledge leaves its source pending for a later full acknowledge.

// File: rtl/irqa_pkg.sv
package irqa_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_FIRST = 2'd1,
      PH_HELD  = 2'd2
   } ack_ph_e;

   localparam int unsigned NO_IRQ_CODE = 0;

   function automatic int unsigned src_total(input int unsigned n_stk,
                                             input int unsigned n_lvl,
                                             input int unsigned n_tmr);
      return 1 + n_stk + n_lvl + n_tmr + 1;
   endfunction
endpackage

// File: rtl/irqa_tmr_latch.sv
module irqa_tmr_latch #(
   parameter int unsigned N_TMR = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N_TMR-1:0] tmr_i,
   input  logic [N_TMR-1:0] rd_i,
   input  logic [N_TMR-1:0] ack_clr_i,
   output logic [N_TMR-1:0] pend_o
);
   if (N_TMR < 1) begin : g_bad_tmr
      $error("irqa_tmr_latch: N_TMR must be at least 1");
   end

   logic [N_TMR-1:0] prev_q;

   for (genvar k = 0; k < N_TMR; k++) begin : g_tmr
      logic rise;
      assign rise = tmr_i[k] & ~prev_q[k];

      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            prev_q[k] <= 1'b0;
            pend_o[k] <= 1'b0;
         end else begin
            prev_q[k] <= tmr_i[k];
            if (rise)
               pend_o[k] <= 1'b1;
            else if (rd_i[k] || ack_clr_i[k])
               pend_o[k] <= 1'b0;
         end
      end

      // R9: every rising edge leaves the timer pending, even against a clear
      p_edge_latch_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(tmr_i[k]) |=> pend_o[k]);
   end
endmodule

// File: rtl/irqa_swi.sv
module irqa_swi (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic we_i,
   input  logic wd_i,
   output logic q_o
);
   always_ff @(posedge clk_i) begin
      if (!rst_ni)
         q_o <= 1'b0;
      else if (we_i)
         q_o <= wd_i;
   end

   p_swi_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i |=> (q_o == $past(wd_i)));
endmodule

// File: rtl/irqa_prio.sv
module irqa_prio #(
   parameter int unsigned N_SRC  = 11,
   parameter int unsigned CODE_W = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [N_SRC-1:0]  req_i,
   input  logic              ext_sup_i,
   input  logic              core_sup_i,
   input  logic              nmi_mode_i,
   output logic              irq_o,
   output logic [CODE_W-1:0] win_o
);
   if (N_SRC >= (1 << CODE_W)) begin : g_bad_width
      $error("irqa_prio: CODE_W too narrow for N_SRC plus the empty code");
   end

   logic [N_SRC-1:0] elig;

   // Index 0 is the non-maskable source; every other index is maskable.
   for (genvar i = 0; i < N_SRC; i++) begin : g_elig
      if (i == 0) begin : g_nmi
         assign elig[i] = req_i[i] & ~(core_sup_i & nmi_mode_i);
      end else begin : g_mask
         assign elig[i] = req_i[i] & ~(ext_sup_i | core_sup_i);
      end
   end

   always_comb begin
      win_o = CODE_W'(irqa_pkg::NO_IRQ_CODE);
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (elig[i]) win_o = CODE_W'(i + 1);
      end
   end

   assign irq_o = |elig;

   // R3: the suppressible mode is fully held off by the core suppress
   p_core_holds_nmi_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (core_sup_i && nmi_mode_i) |-> !irq_o);
   // R2: external suppress never hides the non-maskable source
   p_ext_spares_nmi_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ext_sup_i && !core_sup_i && req_i[0]) |-> (irq_o && win_o == CODE_W'(1)));
   // R1: without suppression any request raises the line
   p_irq_when_free_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ext_sup_i && !core_sup_i && (|req_i)) |-> irq_o);
endmodule

// File: rtl/irqa_ack.sv
module irqa_ack #(
   parameter int unsigned N_SRC  = 11,
   parameter int unsigned CODE_W = 4,
   parameter int unsigned TMR_LO = 7,
   parameter int unsigned N_TMR  = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ack_i,
   input  logic [CODE_W-1:0] win_i,
   input  logic [N_SRC-1:0]  req_i,
   output logic [CODE_W-1:0] vec_o,
   output logic [N_TMR-1:0]  clr_tmr_o
);
   import irqa_pkg::*;

   if (TMR_LO + N_TMR > N_SRC) begin : g_bad_range
      $error("irqa_ack: timer range exceeds source count");
   end

   ack_ph_e           ph_q;
   logic [CODE_W-1:0] sel_q;
   logic [N_SRC-1:0]  hit;
   logic              still;
   logic              confirm;

   for (genvar i = 0; i < N_SRC; i++) begin : g_hit
      assign hit[i] = (sel_q == CODE_W'(i + 1)) & req_i[i];
   end
   assign still   = |hit;
   assign confirm = (ph_q == PH_FIRST) & ack_i & still;

   for (genvar k = 0; k < N_TMR; k++) begin : g_clr
      assign clr_tmr_o[k] = confirm & hit[TMR_LO + k];
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ph_q  <= PH_IDLE;
         sel_q <= CODE_W'(NO_IRQ_CODE);
         vec_o <= CODE_W'(NO_IRQ_CODE);
      end else begin
         unique case (ph_q)
            PH_IDLE: if (ack_i) begin
               ph_q  <= PH_FIRST;
               sel_q <= win_i;
               vec_o <= win_i;
            end
            PH_FIRST: if (ack_i) begin
               ph_q <= PH_HELD;
               if (!still) vec_o <= CODE_W'(NO_IRQ_CODE);
            end else begin
               ph_q  <= PH_IDLE;
               vec_o <= CODE_W'(NO_IRQ_CODE);
            end
            PH_HELD: if (!ack_i) ph_q <= PH_IDLE;
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   // R8: a one-cycle acknowledge returns the empty code
   p_short_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ph_q == PH_FIRST && !ack_i) |=> (vec_o == CODE_W'(NO_IRQ_CODE)));
   // R6: an acknowledge that opens with nothing eligible reports the empty code
   p_empty_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ph_q == PH_IDLE && ack_i && win_i == CODE_W'(NO_IRQ_CODE))
      |=> (vec_o == CODE_W'(NO_IRQ_CODE)));
   // R9: one acknowledge consumes at most one timer
   p_one_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(clr_tmr_o));
   // R5: a latched code never exceeds the source count
   p_code_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vec_o <= CODE_W'(N_SRC));
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
   parameter int unsigned N_STK  = 2,
   parameter int unsigned N_LVL  = 4,
   parameter int unsigned N_TMR  = 3,
   parameter int unsigned CODE_W = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              nmi_i,
   input  logic              nmi_mode_i,
   input  logic [N_STK-1:0]  stk_err_i,
   input  logic [N_LVL-1:0]  lvl_req_i,
   input  logic [N_TMR-1:0]  tmr_i,
   input  logic [N_TMR-1:0]  tmr_rd_i,
   input  logic              swi_we_i,
   input  logic              swi_wd_i,
   input  logic              ext_sup_i,
   input  logic              core_sup_i,
   input  logic              ack_i,
   output logic              irq_o,
   output logic [CODE_W-1:0] vec_o,
   output logic              swi_q_o
);
   localparam int unsigned N_SRC  = irqa_pkg::src_total(N_STK, N_LVL, N_TMR);
   localparam int unsigned TMR_LO = 1 + N_STK + N_LVL;

   if (N_STK < 1 || N_LVL < 1) begin : g_bad_counts
      $error("irq_prio_arb: N_STK and N_LVL must be at least 1");
   end

   logic [N_TMR-1:0]  tmr_pend;
   logic [N_TMR-1:0]  tmr_clr;
   logic [N_SRC-1:0]  req;
   logic [CODE_W-1:0] win;

   assign req = {swi_q_o, tmr_pend, lvl_req_i, stk_err_i, nmi_i};

   irqa_tmr_latch #(.N_TMR(N_TMR)) u_tmr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tmr_i     (tmr_i),
      .rd_i      (tmr_rd_i),
      .ack_clr_i (tmr_clr),
      .pend_o    (tmr_pend)
   );

   irqa_swi u_swi (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (swi_we_i),
      .wd_i   (swi_wd_i),
      .q_o    (swi_q_o)
   );

   irqa_prio #(.N_SRC(N_SRC), .CODE_W(CODE_W)) u_prio (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (req),
      .ext_sup_i  (ext_sup_i),
      .core_sup_i (core_sup_i),
      .nmi_mode_i (nmi_mode_i),
      .irq_o      (irq_o),
      .win_o      (win)
   );

   irqa_ack #(.N_SRC(N_SRC), .CODE_W(CODE_W), .TMR_LO(TMR_LO), .N_TMR(N_TMR)) u_ack (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ack_i     (ack_i),
      .win_i     (win),
      .req_i     (req),
      .vec_o     (vec_o),
      .clr_tmr_o (tmr_clr)
   );
endmodule

// File: tb/irq_prio_arb_bench.sv
`timescale 1ns/1ps
module irq_prio_arb_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       nmi = 0, nmi_mode = 0, swi_we = 0, swi_wd = 0;
   logic       ext_sup = 0, core_sup = 0, ack = 0;
   logic [1:0] stk = '0;
   logic [3:0] lvl = '0;
   logic [2:0] tmr = '0, tmr_rd = '0;
   logic       irq, swi_q;
   logic [3:0] vec;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   irq_prio_arb u_irq_prio_arb (
      .clk_i(clk), .rst_ni(rst_n), .nmi_i(nmi), .nmi_mode_i(nmi_mode),
      .stk_err_i(stk), .lvl_req_i(lvl), .tmr_i(tmr), .tmr_rd_i(tmr_rd),
      .swi_we_i(swi_we), .swi_wd_i(swi_wd), .ext_sup_i(ext_sup),
      .core_sup_i(core_sup), .ack_i(ack), .irq_o(irq), .vec_o(vec),
      .swi_q_o(swi_q)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Expected winner: code = index+1, index 0 is the non-maskable source
   function automatic logic [3:0] f_win(input logic [10:0] r, input logic e,
                                        input logic c, input logic m);
      logic [3:0] w = 4'd0;
      for (int i = 10; i >= 0; i--) begin
         logic ok;
         ok = (i == 0) ? !(c && m) : !(e || c);
         if (r[i] && ok) w = 4'(i + 1);
      end
      return w;
   endfunction

   task automatic step();
      @(posedge clk); @(negedge clk);
   endtask

   // Acknowledge of len cycles (1 or 2); v1 after first edge, v2 once ack ends
   task automatic do_ack(input int len, output int v1, output int v2);
      ack = 1'b1;
      step();
      v1 = vec;
      if (len >= 2) begin
         step();
      end
      ack = 1'b0;
      if (len < 2) step();
      v2 = vec;
      if (len >= 2) step();
   endtask

   initial begin
      int v1, v2;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      #1;
      chk("R11 irq after reset", irq, 0);
      chk("R11 vec after reset", vec, 0);
      chk("R11 swi after reset", swi_q, 0);
      rst_n = 1'b1;
      step(); #1;
      chk("R11 timers idle", irq, 0);

      // R2: external suppress spares the NMI in both modes, blocks the rest
      nmi = 1; nmi_mode = 1; stk = 2'b01; ext_sup = 1; #1;
      chk("R2 nmi visible under ext_sup", irq, 1);
      do_ack(2, v1, v2);
      chk("R2 nmi code", v1, 1);
      chk("R5 code held", v2, 1);
      nmi = 0; #1;
      chk("R2 stack error blocked", irq, 0);
      stk = 0; ext_sup = 0;

      // R3: core suppress and the NMI mode
      nmi = 1; nmi_mode = 1; core_sup = 1; #1;
      chk("R3 mode1 nmi held off", irq, 0);
      nmi_mode = 0; #1;
      chk("R3 mode0 nmi not held", irq, 1);
      do_ack(2, v1, v2);
      chk("R3 mode0 nmi code", v1, 1);
      nmi = 0; lvl = 4'b0001; #1;
      chk("R3 level held by core_sup", irq, 0);
      core_sup = 0; lvl = 0;

      // R4: withdrawn request skipped after suppression
      ext_sup = 1; lvl = 4'b0101; step(); #1;
      chk("R4 suppressed", irq, 0);
      lvl = 4'b0100; step(); ext_sup = 0; #1;
      chk("R4 survivor raises irq", irq, 1);
      do_ack(2, v1, v2);
      chk("R4 survivor code", v1, 6);
      lvl = 0;

      // R6: acknowledge with nothing eligible
      do_ack(2, v1, v2);
      chk("R6 empty code", v1, 0);

      // R7: source withdrawn between the two acknowledge cycles
      lvl = 4'b0010; ack = 1; step();
      chk("R7 first code", vec, 5);
      lvl = 0; step(); ack = 0;
      chk("R7 withdrawn gives 0", vec, 0);
      step();

      // R8 and R9: one-cycle ack leaves timer pending, full ack consumes it
      tmr[0] = 1; step(); tmr[0] = 0; #1;
      chk("R9 timer edge pending", irq, 1);
      do_ack(1, v1, v2);
      chk("R8 short ack first code", v1, 8);
      chk("R8 short ack gives 0", v2, 0);
      #1 chk("R8 timer still pending", irq, 1);
      do_ack(2, v1, v2);
      chk("R9 timer code", v1, 8);
      #1 chk("R9 timer consumed", irq, 0);

      // R9: read clear, and edge wins over clear
      tmr[1] = 1; step(); tmr[1] = 0; tmr_rd[1] = 1; step(); tmr_rd = 0; #1;
      chk("R9 read clears timer", irq, 0);
      tmr[2] = 1; tmr_rd[2] = 1; step(); tmr = 0; tmr_rd = 0; #1;
      chk("R9 edge beats clear", irq, 1);
      do_ack(2, v1, v2);
      chk("R9 timer2 code", v1, 10);
      tmr_rd[2] = 1; step(); tmr_rd = 0;

      // R10: software flag
      swi_we = 1; swi_wd = 1; step(); swi_we = 0; #1;
      chk("R10 flag set", swi_q, 1);
      do_ack(2, v1, v2);
      chk("R10 swi code", v1, 11);
      #1 chk("R10 flag survives ack", swi_q, 1);
      swi_we = 1; swi_wd = 0; step(); swi_we = 0; #1;
      chk("R10 flag cleared", swi_q, 0);
      chk("R10 irq drops", irq, 0);

      // R1: random mixes of level sources against the model
      for (int n = 0; n < 300; n++) begin
         logic [10:0] r;
         logic [3:0]  w;
         nmi = 1'($urandom); stk = 2'($urandom); lvl = 4'($urandom);
         ext_sup = ($urandom % 4) == 0; core_sup = ($urandom % 4) == 0;
         nmi_mode = 1'($urandom);
         r = {4'b0, lvl, stk, nmi};
         w = f_win(r, ext_sup, core_sup, nmi_mode);
         #1;
         chk("R1 irq vs model", irq, (w != 0) ? 1 : 0);
         do_ack(2, v1, v2);
         chk("R1 code vs model", v1, w);
         chk("R5 code stable", v2, w);
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule